// File: doc/BRIEF.md
# Parking Centralized Bus Arbiter

This block is a synchronous, centralized arbiter for a shared bus with several masters. Each master has a private request line into the arbiter and a private grant line back from it. The arbiter chooses the next owner while the current owner is still transferring. When the owner signals that its transaction has ended, the waiting master takes over on the very next cycle.

When nobody else is asking for the bus, the grant stays with the last owner. That owner can then run further transactions without arbitrating again. Priority rotates after every handover, so no requester can be starved. An owner that holds the bus too long while another master waits loses its grant line. The bus itself does not change hands until that owner reports that it has finished.

Top module: `bus_park_arbiter`

## Requirements
- R1: After reset, `gnt_o` equals 1 in bit 0 only: the bus is parked on master 0. Bit i of `gnt_o` and bit i of `req_i` always belong to master i.
- R2: At most one bit of `gnt_o` is high in any cycle.
- R3: Ownership changes only at a clock edge where `done_i` is high and a waiting master was selected at an earlier edge. The new owner's grant bit is high in the cycle right after that edge.
- R4: If `done_i` is high and no other master was waiting, the grant stays on the current owner (parking).
- R5: The waiting master is chosen by rotating priority. The search starts at the master numbered one above the last master to receive the bus (modulo the master count) and goes upward, wrapping around. After reset the search starts at master 1.
- R6: Arbitration overlaps the transfer. A request seen at an edge before the owner's `done_i` edge is served with no idle cycle: the grant moves in the cycle immediately after `done_i`.
- R7: A master becomes owner at some edge, and `done_i` stays low after it. If a waiter exists at the edge that follows HOLD_LIMIT further edges, `gnt_o` goes to all zeros one cycle later and stays zero until `done_i`. One edge earlier, the owner's grant is still high.
- R8: A master that keeps requesting is granted within NUM_MASTERS-1 handovers to other masters.
- R9: The owner's own request line is ignored. A parked owner keeps its grant with its request low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_MASTERS | Request line of each master |
| done_i | input | 1 | Current owner has finished its transaction, bus is free |
| gnt_o | output | NUM_MASTERS | One-hot (or zero) grant line of each master |

## Verification
The embedded assertions check the following on every cycle:
- the grant is one-hot or zero;
- ownership never moves without `done_i`;
- a `done_i` with no waiter leaves the owner in place;
- an expired hold budget with a waiter clears the grant;
- the per-master handover count behind a steady requester stays bounded.

Only the bench's scenarios can show two further points. The first is the exact rotation order after several handovers. The second is the exact cycle at which a revoke begins, one edge past the hold budget. Both are compared against a behavioural model under directed and randomized request and done patterns.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    // Circular successor of a master index.
    function automatic int next_slot(input int cur, input int n);
        return (cur + 1) % n;
    endfunction
endpackage

// File: rtl/rot_pick.sv
module rot_pick #(
    parameter int NUM_MASTERS = 4,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [IDX_W-1:0]       ptr_i,
    output logic [IDX_W-1:0]       idx_o,
    output logic                   vld_o
);
    // Scan from ptr_i upward with wrap; the first requester wins.
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int k = 0; k < NUM_MASTERS; k++) begin
            int j;
            j = (int'(ptr_i) + k) % NUM_MASTERS;
            if (!vld_o && req_i[j]) begin
                idx_o = IDX_W'(j);
                vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_LIMIT = 8,
    localparam int CNT_W = $clog2(HOLD_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic done_i,
    input  logic waiter_i,
    output logic revoke_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rvk;
    } hold_t;

    hold_t hs_q, hs_d;

    always_comb begin
        hs_d = hs_q;
        if (restart_i) begin
            hs_d.cnt = '0;
            hs_d.rvk = 1'b0;
        end else begin
            if (hs_q.cnt != CNT_W'(HOLD_LIMIT))
                hs_d.cnt = hs_q.cnt + 1'b1;
            if (done_i)
                hs_d.rvk = 1'b0;
            else if (waiter_i && hs_q.cnt == CNT_W'(HOLD_LIMIT))
                hs_d.rvk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign revoke_o = hs_q.rvk;

    // R7: budget spent with a waiter and no finish -> revoke next cycle
    a_r7_revoke_set: assert property (@(posedge clk) disable iff (!rst_n)
        (waiter_i && !restart_i && !done_i && hs_q.cnt == CNT_W'(HOLD_LIMIT)) |=> revoke_o);

    // R7: a revoke is never raised before the budget is spent
    a_r7_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(revoke_o) |-> $past(hs_q.cnt) == CNT_W'(HOLD_LIMIT));
endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
    import bpa_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int HOLD_LIMIT  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic                   done_i,
    output logic [NUM_MASTERS-1:0] gnt_o
);
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam int WC_W  = $clog2(NUM_MASTERS + 1) + 1;

    typedef struct packed {
        logic [IDX_W-1:0] own;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] nxt;
        logic             nvld;
    } arb_t;

    arb_t st_q, st_d;

    logic [NUM_MASTERS-1:0] owner_oh;
    logic [NUM_MASTERS-1:0] cand;
    logic [IDX_W-1:0]       win;
    logic                   win_vld;
    logic                   handover;
    logic                   revoke;

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_oh
        assign owner_oh[g] = (st_q.own == IDX_W'(g));
    end

    // The owner never competes against itself (R9).
    assign cand     = req_i & ~owner_oh;
    assign handover = done_i & st_q.nvld;

    rot_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .req_i (cand),
        .ptr_i (st_q.ptr),
        .idx_o (win),
        .vld_o (win_vld)
    );

    hold_timer #(.HOLD_LIMIT(HOLD_LIMIT)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (handover),
        .done_i    (done_i),
        .waiter_i  (st_q.nvld),
        .revoke_o  (revoke)
    );

    always_comb begin
        st_d = st_q;
        if (handover) begin
            st_d.own  = st_q.nxt;
            st_d.ptr  = IDX_W'(next_slot(int'(st_q.nxt), NUM_MASTERS));
            st_d.nvld = 1'b0;
        end else begin
            st_d.nxt  = win;
            st_d.nvld = win_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.own  <= '0;
            st_q.ptr  <= IDX_W'(next_slot(0, NUM_MASTERS));
            st_q.nxt  <= '0;
            st_q.nvld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = owner_oh & {NUM_MASTERS{~revoke}};

    // R2: never two grants
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R3: ownership stays put unless the owner reports completion
    a_r3_hold_without_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> st_q.own == $past(st_q.own));

    // R4: completion with nobody waiting parks the grant
    a_r4_park: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !st_q.nvld) |=> st_q.own == $past(st_q.own));

    // R7: once revoked, the grant stays off until completion
    a_r7_gnt_off: assert property (@(posedge clk) disable iff (!rst_n)
        (revoke && !done_i) |=> gnt_o == '0);

    // R8: handovers passing over a steady requester stay bounded
    logic [NUM_MASTERS-1:0] preq_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) preq_q <= '0;
        else        preq_q <= req_i;
    end

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_fair
        logic [WC_W-1:0] wc_q, wc_d;
        always_comb begin
            wc_d = wc_q;
            if (!req_i[g] || owner_oh[g])
                wc_d = '0;
            else if (handover && preq_q[g] && st_q.nxt != IDX_W'(g) && wc_q != '1)
                wc_d = wc_q + 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wc_q <= '0;
            else        wc_q <= wc_d;
        end
        a_r8_fair: assert property (@(posedge clk) disable iff (!rst_n)
            wc_q <= WC_W'(NUM_MASTERS - 1));
    end
endmodule

// File: tb/tb_bus_park_arbiter.sv
module tb_bus_park_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int LIMIT = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         done = 1'b0;
    logic [N-1:0] gnt;

    int tests = 0;
    int fails = 0;
    bit run_cmp = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_park_arbiter #(.NUM_MASTERS(N), .HOLD_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done), .gnt_o(gnt)
    );

    // Behavioural reference model
    int m_own, m_ptr, m_nxt, m_hold;
    bit m_nvld, m_rvk;
    int m_wait[N];
    bit m_preq[N];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = 0; m_ptr = 1 % N; m_nxt = 0; m_nvld = 0; m_hold = 0; m_rvk = 0;
            for (int i = 0; i < N; i++) begin m_wait[i] = 0; m_preq[i] = 0; end
        end else begin
            bit ho;
            bit nrvk;
            int w;
            int prev_own;
            ho = done && m_nvld;
            prev_own = m_own;
            w = -1;
            for (int k = 0; k < N; k++) begin
                int j;
                j = (m_ptr + k) % N;
                if (w < 0 && req[j] && j != m_own) w = j;
            end
            for (int i = 0; i < N; i++)
                if (ho && m_nxt != i && m_preq[i] && req[i]) m_wait[i]++;
            if (ho) begin
                m_hold = 0; m_rvk = 0;
            end else begin
                nrvk = done ? 1'b0 : (m_rvk || (m_nvld && m_hold == LIMIT));
                if (m_hold < LIMIT) m_hold++;
                m_rvk = nrvk;
            end
            if (ho) begin
                m_own = m_nxt; m_ptr = (m_nxt + 1) % N; m_nvld = 0;
            end else begin
                m_nvld = (w >= 0);
                if (w >= 0) m_nxt = w;
            end
            if (m_own != prev_own) begin
                tests++;
                if (m_wait[m_own] > N - 1) begin
                    fails++;
                    $display("FAIL R8: master %0d waited %0d handovers, expected <= %0d",
                             m_own, m_wait[m_own], N - 1);
                end
            end
            for (int i = 0; i < N; i++) begin
                m_preq[i] = req[i];
                if (!req[i] || m_own == i) m_wait[i] = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: gnt=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Continuous comparison against the model (R3, R5, R7)
    always @(negedge clk) begin
        if (run_cmp) begin
            logic [N-1:0] exp;
            exp = m_rvk ? '0 : (N'(1) << m_own);
            chk("R3 model", gnt, exp);
            tests++;
            if ($countones(gnt) > 1) begin
                fails++;
                $display("FAIL R2: gnt=%b expected at most one bit", gnt);
            end
        end
    end

    task automatic drive(input logic [N-1:0] r, input logic d);
        req = r; done = d;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset parks on master 0", gnt, 4'b0001);
        run_cmp = 1'b1;

        // R4/R9: completions with no waiter, owner not requesting
        drive(4'b0000, 1'b1);
        drive(4'b0000, 1'b1);
        chk("R4 park without waiter", gnt, 4'b0001);
        drive(4'b0001, 1'b1);
        chk("R9 own request ignored", gnt, 4'b0001);

        // R6: request seen before done, handover right after done
        drive(4'b0100, 1'b0);
        chk("R3 no move without done", gnt, 4'b0001);
        drive(4'b0100, 1'b1);
        chk("R6 overlapped handover", gnt, 4'b0100);

        // R5: rotation from master 3 onward
        drive(4'b1011, 1'b0);
        drive(4'b1011, 1'b1);
        chk("R5 rotate to 3", gnt, 4'b1000);
        drive(4'b1011, 1'b0);
        drive(4'b1011, 1'b1);
        chk("R5 wrap to 0", gnt, 4'b0001);
        drive(4'b1011, 1'b0);
        drive(4'b1011, 1'b1);
        chk("R5 rotate to 1", gnt, 4'b0010);

        // R7: owner 1 holds, master 3 waits
        for (int k = 0; k < LIMIT; k++) drive(4'b1011, 1'b0);
        chk("R7 grant kept at budget", gnt, 4'b0010);
        drive(4'b1011, 1'b0);
        chk("R7 grant revoked", gnt, 4'b0000);
        drive(4'b1011, 1'b0);
        chk("R7 revoke held", gnt, 4'b0000);
        drive(4'b1011, 1'b1);
        chk("R7 handover after revoke", gnt, 4'b1000);

        // Randomized phase: sticky requests, random completions (R5, R8)
        rq = '0;
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (($urandom % 8) == 0) rq[i] = 1'b1;
                if (gnt[i] && ($urandom % 2) == 0) rq[i] = 1'b0;
            end
            drive(rq, (($urandom % 4) == 0));
        end

        run_cmp = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule